// File: doc/BRIEF.md
# Byte/Word Stack Push-Pop Unit

This block carries out the stack push and pop instructions of an 8-bit processor core. The stack is byte addressed and grows toward lower addresses. The block owns the 16-bit stack pointer. It decodes the 8-bit opcode of a stack instruction and runs the transfer on a synchronous, byte-wide memory port. The memory returns read data on the cycle after it sees an address. The port has an address, write data, a write strobe and a read-data return.

A data register moves through one memory byte. An address register moves through two bytes, stored low byte first. For a push, the caller presents the opcode together with the contents of the named register. For a pop, the block hands back the value, the register index and a write strobe, which the caller applies to its register file.

Every form moves the pointer before its stores on a push and after its loads on a pop. Each form has its own fixed latency. A busy flag guards the block from overlapping commands.

Top module: `stk_xfer_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `sp` equals the parameter `SP_INIT` and `busy`, `done`, `mem_we` and `rf_we` are all 0.
- R2: With `busy` low and `cmd_valid` high, the opcode is decoded as follows: `111110dd` pushes data register dd, `0001011a` pushes address register a, `111010dd` pops into data register dd, and `0000011a` pops into address register a.
- R3: A byte push lowers `sp` by 1 and then stores the low byte of `cmd_src` at the new `sp`. `done` is high on the cycle after the 3rd rising edge, counting the accepting edge as the 1st.
- R4: A word push lowers `sp` by 2 and then stores `cmd_src[7:0]` at the new `sp` and `cmd_src[15:8]` at new `sp`+1. `done` is high after the 5th edge, and both stores have been committed by then.
- R5: A byte pop reads the byte at `sp` and returns it in `rf_wdata` with the upper byte zero. It then raises `sp` by 1, and `done` is high after the 3rd edge.
- R6: A word pop returns `{mem[sp+1], mem[sp]}` in `rf_wdata`. It then raises `sp` by 2, and `done` is high after the 4th edge.
- R7: All stack pointer and address arithmetic wraps modulo 2^16, so a word at 0xFFFF has its high byte at 0x0000.
- R8: `busy` is high from the accepting edge until the `done` cycle, in which it is low. `done` lasts exactly one cycle. A `cmd_valid` seen while `busy` is high is ignored.
- R9: An opcode outside the four forms of R2 is ignored: `busy` stays low, `sp` is unchanged and no store is made.
- R10: `rf_we` is high only in the `done` cycle of a pop. It is then accompanied by `rf_idx` (dd, or a in bit 0 with bit 1 zero) and by `rf_word` (1 for an address register).
- R11: A byte push makes exactly one store and a word push exactly two; a pop makes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Stack instruction opcode |
| cmd_src | input | 16 | Contents of the register a push names |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read byte, one cycle after the address |
| rf_we | output | 1 | Register write strobe for a pop |
| rf_word | output | 1 | Pop target is an address register |
| rf_idx | output | 2 | Pop target register index |
| rf_wdata | output | 16 | Popped value |

## Verification
The bench builds the unit with `SP_INIT` = 0x0003, three bytes above the bottom of the address space. The first pushes therefore carry the pointer through 0x0000 into 0xFFFF. A word can then be stored split across the wrap, and popping it back recombines both halves. Widths stay at their defaults, so the 8-bit opcode encodings and little-endian byte order are exercised exactly as stated.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  typedef enum logic [1:0] {
    K_PUSH_B = 2'd0,
    K_PUSH_W = 2'd1,
    K_POP_B  = 2'd2,
    K_POP_W  = 2'd3
  } kind_t;

  typedef struct packed {
    logic       ok;
    kind_t      kind;
    logic [1:0] idx;
  } dec_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PB_DEC,
    ST_PB_FIN,
    ST_PW_DEC,
    ST_PW_LO,
    ST_PW_HI,
    ST_PW_FIN,
    ST_QB_WAIT,
    ST_QB_FIN,
    ST_QW_LO,
    ST_QW_CAP,
    ST_QW_FIN
  } state_t;
endpackage

// File: rtl/stk_opdec.sv
`timescale 1ns/1ps
module stk_opdec
  import stk_pkg::*;
(
  input  logic [7:0] op,
  output dec_t       dec
);
  always_comb begin
    dec = '0;
    if (op[7:2] == 6'b111110) begin
      dec.ok   = 1'b1;
      dec.kind = K_PUSH_B;
      dec.idx  = op[1:0];
    end else if (op[7:1] == 7'b0001011) begin
      dec.ok   = 1'b1;
      dec.kind = K_PUSH_W;
      dec.idx  = {1'b0, op[0]};
    end else if (op[7:2] == 6'b111010) begin
      dec.ok   = 1'b1;
      dec.kind = K_POP_B;
      dec.idx  = op[1:0];
    end else if (op[7:1] == 7'b0000011) begin
      dec.ok   = 1'b1;
      dec.kind = K_POP_W;
      dec.idx  = {1'b0, op[0]};
    end
  end
endmodule

// File: rtl/stk_spreg.sv
`timescale 1ns/1ps
module stk_spreg #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              down,
  input  logic              two,
  output logic [ADDR_W-1:0] sp
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] delta;
  assign delta = two ? TWO : ONE;

  // modulo 2^ADDR_W by plain truncation
  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= SP_INIT;
    end else if (step) begin
      sp <= down ? (sp - delta) : (sp + delta);
    end
  end
endmodule

// File: rtl/stk_seq.sv
`timescale 1ns/1ps
module stk_seq
  import stk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  dec_t              dec,
  input  logic [WORD_W-1:0] src,
  input  logic [ADDR_W-1:0] sp,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              sp_step,
  output logic              sp_down,
  output logic              sp_two,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic              done,
  output logic              rf_we,
  output logic              rf_word,
  output logic [1:0]        rf_idx,
  output logic [WORD_W-1:0] rf_wdata
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

  state_t            state;
  logic [WORD_W-1:0] held;
  logic [BYTE_W-1:0] lo_q;

  always_comb begin
    sp_step = (state == ST_PB_DEC) || (state == ST_PW_DEC) ||
              (state == ST_QB_FIN) || (state == ST_QW_FIN);
    sp_down = (state == ST_PB_DEC) || (state == ST_PW_DEC);
    sp_two  = (state == ST_PW_DEC) || (state == ST_QW_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      held      <= '0;
      lo_q      <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rf_we     <= 1'b0;
      rf_word   <= 1'b0;
      rf_idx    <= '0;
      rf_wdata  <= '0;
    end else begin
      done   <= 1'b0;
      rf_we  <= 1'b0;
      mem_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid && dec.ok) begin
            busy    <= 1'b1;
            held    <= src;
            rf_idx  <= dec.idx;
            rf_word <= (dec.kind == K_PUSH_W) || (dec.kind == K_POP_W);
            case (dec.kind)
              K_PUSH_B: state <= ST_PB_DEC;
              K_PUSH_W: state <= ST_PW_DEC;
              K_POP_B: begin
                mem_addr <= sp;
                state    <= ST_QB_WAIT;
              end
              default: begin
                mem_addr <= sp;
                state    <= ST_QW_LO;
              end
            endcase
          end
        end
        ST_PB_DEC: begin
          mem_addr  <= sp - A_ONE;
          mem_wdata <= held[BYTE_W-1:0];
          mem_we    <= 1'b1;
          state     <= ST_PB_FIN;
        end
        ST_PW_DEC: state <= ST_PW_LO;
        ST_PW_LO: begin
          mem_addr  <= sp;
          mem_wdata <= held[BYTE_W-1:0];
          mem_we    <= 1'b1;
          state     <= ST_PW_HI;
        end
        ST_PW_HI: begin
          mem_addr  <= sp + A_ONE;
          mem_wdata <= held[WORD_W-1:BYTE_W];
          mem_we    <= 1'b1;
          state     <= ST_PW_FIN;
        end
        ST_QB_WAIT: state <= ST_QB_FIN;
        ST_QW_LO: begin
          mem_addr <= sp + A_ONE;
          state    <= ST_QW_CAP;
        end
        ST_QW_CAP: begin
          lo_q  <= mem_rdata;
          state <= ST_QW_FIN;
        end
        ST_QB_FIN: begin
          rf_wdata <= {{BYTE_W{1'b0}}, mem_rdata};
          rf_we    <= 1'b1;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        ST_QW_FIN: begin
          rf_wdata <= {mem_rdata, lo_q};
          rf_we    <= 1'b1;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        ST_PB_FIN, ST_PW_FIN: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/stk_xfer_unit.sv
`timescale 1ns/1ps
module stk_xfer_unit
  import stk_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                BYTE_W  = 8,
  parameter logic [ADDR_W-1:0] SP_INIT = '0,
  localparam int               WORD_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_src,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic              rf_word,
  output logic [1:0]        rf_idx,
  output logic [WORD_W-1:0] rf_wdata
);
  dec_t dec;
  logic sp_step, sp_down, sp_two;

  stk_opdec u_dec (
    .op  (cmd_op),
    .dec (dec)
  );

  stk_spreg #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_sp (
    .clk  (clk),
    .rst  (rst),
    .step (sp_step),
    .down (sp_down),
    .two  (sp_two),
    .sp   (sp)
  );

  stk_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .dec       (dec),
    .src       (cmd_src),
    .sp        (sp),
    .mem_rdata (mem_rdata),
    .sp_step   (sp_step),
    .sp_down   (sp_down),
    .sp_two    (sp_two),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done),
    .rf_we     (rf_we),
    .rf_word   (rf_word),
    .rf_idx    (rf_idx),
    .rf_wdata  (rf_wdata)
  );
endmodule

// File: rtl/stk_xfer_chk.sv
`timescale 1ns/1ps
module stk_xfer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic              rf_we,
  input logic              rf_word,
  input logic [1:0]        rf_idx,
  input logic [ADDR_W-1:0] sp
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                            // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                            // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));                               // R8
  AST_RF_WE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);                                            // R10
  AST_ADDR_REG_IDX: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_word) |-> !rf_idx[1]);                         // R10
  AST_SP_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_valid) |=> $stable(sp));                     // R9
  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);                                           // R11
endmodule

bind stk_xfer_unit stk_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .mem_we    (mem_we),
  .rf_we     (rf_we),
  .rf_word   (rf_word),
  .rf_idx    (rf_idx),
  .sp        (sp)
);

// File: tb/stk_xfer_unit_bench.sv
`timescale 1ns/1ps
module stk_xfer_unit_bench;
  localparam logic [15:0] INIT = 16'h0003;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [15:0] cmd_src = 16'h0000;
  logic        busy, done, mem_we, rf_we, rf_word;
  logic [15:0] sp, mem_addr, rf_wdata;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  rf_idx;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  bit in_pop = 1'b0;
  int pop_wr = 0;

  logic [7:0]  bmem [256];
  logic [7:0]  ref_mem [256];
  logic [15:0] exp_sp;

  always #2.5 clk = ~clk;

  stk_xfer_unit #(.SP_INIT(INIT)) u_stk_xfer_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .busy(busy), .done(done), .sp(sp),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_word(rf_word),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata)
  );

  // synchronous byte memory, low address byte selects
  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (in_pop) pop_wr <= pop_wr + 1;
    end
    mem_rdata <= bmem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [1:0] k);
    case (k)
      2'd0: return 3;
      2'd1: return 5;
      2'd2: return 3;
      default: return 4;
    endcase
  endfunction

  // 0 push byte, 1 push word, 2 pop byte, 3 pop word, 4 none
  function automatic logic [2:0] bench_kind(input logic [7:0] op);
    if (op[7:2] == 6'b111110) return 3'd0;
    if (op[7:1] == 7'b0001011) return 3'd1;
    if (op[7:2] == 6'b111010) return 3'd2;
    if (op[7:1] == 7'b0000011) return 3'd3;
    return 3'd4;
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [15:0] data,
                        input bit intrude);
    logic [2:0]  k;
    logic [15:0] exp_val;
    logic [1:0]  exp_idx;
    string       rq;
    int          n;
    int          w0;
    k = bench_kind(op);
    exp_val = 16'h0000;
    exp_idx = (k == 3'd0 || k == 3'd2) ? op[1:0] : {1'b0, op[0]};
    rq = (k == 3'd0) ? "R3" : (k == 3'd1) ? "R4" : (k == 3'd2) ? "R5" : "R6";
    case (k)
      3'd0: begin
        exp_sp = exp_sp - 16'd1;
        ref_mem[exp_sp[7:0]] = data[7:0];
      end
      3'd1: begin
        exp_sp = exp_sp - 16'd2;
        ref_mem[exp_sp[7:0]] = data[7:0];
        ref_mem[8'(exp_sp[7:0] + 8'd1)] = data[15:8];
      end
      3'd2: begin
        exp_val = {8'h00, ref_mem[exp_sp[7:0]]};
        exp_sp = exp_sp + 16'd1;
      end
      default: begin
        exp_val = {ref_mem[8'(exp_sp[7:0] + 8'd1)], ref_mem[exp_sp[7:0]]};
        exp_sp = exp_sp + 16'd2;
      end
    endcase
    @(negedge clk);
    chk(!busy, "R8", "idle before command", 32'(busy), 32'd0);
    in_pop = (k >= 3'd2);
    w0 = wr_cnt;
    cmd_valid = 1'b1; cmd_op = op; cmd_src = data;
    @(negedge clk);
    chk(busy, "R8", "busy after accept", 32'(busy), 32'd1);
    if (intrude) begin
      cmd_op = 8'hF8; cmd_src = 16'h00EE;   // push byte while busy: ignored
    end else begin
      cmd_valid = 1'b0;
    end
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      n++;
    end
    cmd_valid = 1'b0;
    chk(n == exp_lat(k[1:0]), rq, "latency", 32'(n), 32'(exp_lat(k[1:0])));
    chk(sp == exp_sp, intrude ? "R8" : rq, "sp after op", 32'(sp), 32'(exp_sp));
    chk(!busy, "R8", "busy low in done cycle", 32'(busy), 32'd0);
    chk(rf_we == (k >= 3'd2), "R10", "rf_we at done", 32'(rf_we), 32'(k >= 3'd2));
    if (k >= 3'd2) begin
      chk(rf_wdata == exp_val, rq, "popped value", 32'(rf_wdata), 32'(exp_val));
      chk(rf_idx == exp_idx, "R10", "rf_idx", 32'(rf_idx), 32'(exp_idx));
      chk(rf_word == (k == 3'd3), "R10", "rf_word", 32'(rf_word), 32'(k == 3'd3));
      chk(wr_cnt == w0, "R11", "no store on pop", 32'(wr_cnt - w0), 32'd0);
    end else begin
      chk(wr_cnt - w0 == ((k == 3'd1) ? 2 : 1), "R11", "store count",
          32'(wr_cnt - w0), (k == 3'd1) ? 32'd2 : 32'd1);
      chk(bmem[exp_sp[7:0]] == data[7:0], rq, "low byte at sp",
          32'(bmem[exp_sp[7:0]]), 32'(data[7:0]));
      if (k == 3'd1)
        chk(bmem[8'(exp_sp[7:0] + 8'd1)] == data[15:8], "R4", "high byte at sp+1",
            32'(bmem[8'(exp_sp[7:0] + 8'd1)]), 32'(data[15:8]));
    end
    @(negedge clk);
    chk(!done, "R8", "done one cycle", 32'(done), 32'd0);
    chk(sp == exp_sp, "R8", "no late effect", 32'(sp), 32'(exp_sp));
    in_pop = 1'b0;
  endtask

  task automatic bad_op(input logic [7:0] op);
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_src = 16'hA5A5;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!busy && !done, "R9", "no busy on bad opcode", 32'({busy, done}), 32'd0);
      @(negedge clk);
    end
    chk(sp == exp_sp, "R9", "sp unchanged", 32'(sp), 32'(exp_sp));
    chk(wr_cnt == w0, "R9", "no store", 32'(wr_cnt - w0), 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int depth;
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'h00;
      ref_mem[i] = 8'h00;
    end
    exp_sp = INIT;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: state during and after reset
    chk(sp == INIT && !busy && !done && !mem_we && !rf_we, "R1", "in reset",
        32'({sp, busy, done, mem_we, rf_we}), 32'({INIT, 4'b0000}));
    rst = 1'b0;
    @(negedge clk);
    chk(sp == INIT && !busy && !done && !mem_we && !rf_we, "R1", "after reset",
        32'({sp, busy, done, mem_we, rf_we}), 32'({INIT, 4'b0000}));

    // R2/R7 directed: cross the bottom of memory
    run_op(8'h17, 16'hBEEF, 1'b0);   // push addr reg 1: sp 3 -> 1
    run_op(8'h16, 16'h1234, 1'b0);   // push addr reg 0: sp -> FFFF, split word
    chk(exp_sp == 16'hFFFF && bmem[8'hFF] == 8'h34 && bmem[8'h00] == 8'h12, "R7",
        "word across wrap", 32'({bmem[8'hFF], bmem[8'h00]}), 32'h3412);
    run_op(8'hFA, 16'h0077, 1'b0);   // push data reg 2: sp -> FFFE
    run_op(8'hE9, 16'h0000, 1'b0);   // pop data reg 1
    run_op(8'h07, 16'h0000, 1'b0);   // pop addr reg 1 -> 1234, sp -> 0001
    chk(sp == 16'h0001, "R7", "sp back over wrap", 32'(sp), 32'h0001);
    run_op(8'h06, 16'h0000, 1'b0);   // pop addr reg 0 -> BEEF
    chk(sp == INIT, "R2", "balanced sequence", 32'(sp), 32'(INIT));

    // R8: command attempted while busy
    run_op(8'hFB, 16'h0042, 1'b1);
    run_op(8'h16, 16'hCAFE, 1'b1);
    run_op(8'hEB, 16'h0000, 1'b1);
    run_op(8'h07, 16'h0000, 1'b1);

    // R9: opcodes outside the stack forms
    bad_op(8'hFC);
    bad_op(8'h04);
    bad_op(8'h18);
    bad_op(8'hE4);

    // random mix
    for (int i = 0; i < 300; i++) begin
      r = $urandom;
      depth = int'(16'(INIT - exp_sp));
      case (r[1:0])
        2'd0: if (depth < 200) run_op({6'b111110, r[9:8]}, r[31:16], r[12]);
        2'd1: if (depth < 200) run_op({7'b0001011, r[8]}, r[31:16], r[12]);
        2'd2: if (depth >= 1) run_op({6'b111010, r[9:8]}, 16'h0000, r[12]);
        default: if (depth >= 2) run_op({7'b0000011, r[8]}, 16'h0000, r[12]);
      endcase
    end
    chk(pop_wr == 0, "R11", "pops never store", 32'(pop_wr), 32'd0);
    finish_run();
  end
endmodule